// File: doc/BRIEF.md
# Sleep-Triggered Converter Sequencer

This block sequences conversions for a 10-bit analog converter core. It reaches the core only through a start pulse, the latched channel and reference select, a done strobe and a raw result word. A conversion can be started by software, can restart itself in free-running mode, or can start by itself at the moment the CPU halts in one of the two quiet sleep modes. In the last case the completion interrupt then wakes the CPU.

The sequencer keeps a shadow copy of the channel and reference for each conversion, so settings written mid-conversion never reach the conversion in flight. In free-running mode a channel change takes effect one conversion later than written, because the next conversion is already under way when the write lands. Results are clamped to 10 bits. The first result after a reference change carries a discard mark. A sticky completion flag drives the interrupt line.

Top module: `adc_sleep_seq`

## Requirements
- R1: With `en_i` high and no conversion in flight, a one-cycle `start_i` makes `conv_start_o` pulse in the next cycle. `busy_o` is high from that cycle until the cycle after the accepted `conv_done_i`.
- R2: A `conv_done_i` accepted while busy makes `res_stb_o` pulse in the next cycle. `result_o` then holds the raw code when it is below 1023 and 10'h3FF (1023) when the raw code is 1023 or more.
- R3: With `free_run_i` high, every accepted done starts the next conversion at once (a `conv_start_o` pulse in the cycle after done). Clearing `free_run_i` before a done lets that conversion end the run.
- R4: The channel and reference are latched at each start, and `conv_chan_o`/`res_chan_o` do not follow writes made during a conversion. In free-running mode, the conversion started automatically after a channel write still uses the channel that was current when the previous conversion started. The written channel applies from the conversion after that.
- R5: `ref_sel_i` picks the supply (0) or the internal 1.1 V reference (1), and the reference state after reset is 0. The result of a conversion whose reference differs from that of the previous conversion has `discard_o` high; otherwise `discard_o` is low.
- R6: A rising edge of `halted_i` starts one conversion (start pulse in the next cycle) only when `sleep_mode_i` is 2'b00 (idle) or 2'b01 (noise reduction), `en_i` is high, no conversion is in flight, `free_run_i` is low and `irq_en_i` is high.
- R7: While `halted_i` stays high, no further sleep-triggered conversion starts. A new one needs `halted_i` to fall and rise again.
- R8: Sleep modes 2'b10 and 2'b11 never start a conversion, and halting in them leaves `power_o` high. `power_o` follows `en_i` one cycle later.
- R9: If `halted_i` falls (another wake source) before a sleep-triggered conversion completes, the conversion still completes and sets the flag, and `irq_o` rises.
- R10: The completion flag `flag_o` sets on every completion and stays set until `flag_clr_i` or `irq_ack_i` is high. A set and a clear in the same cycle leave it set.
- R11: `irq_o` is high exactly while `flag_o` and `irq_en_i` are both high.
- R12: Dropping `en_i` aborts a conversion: `busy_o` and `power_o` are low in the next cycle. A done that arrives while nothing is in flight produces no result and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| free_run_i | input | 1 | 1 = free-running, 0 = single conversion |
| start_i | input | 1 | Software start pulse |
| chan_i | input | CH_W | Channel setting |
| ref_sel_i | input | 1 | 0 = supply reference, 1 = internal 1.1 V |
| irq_en_i | input | 1 | Completion interrupt enable |
| halted_i | input | 1 | CPU halted in sleep |
| sleep_mode_i | input | 2 | Current sleep mode (00 idle, 01 noise reduction, 10/11 deeper) |
| flag_clr_i | input | 1 | Write-one-to-clear for the flag |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| conv_done_i | input | 1 | Core done strobe |
| conv_raw_i | input | RAW_W | Core raw code |
| conv_start_o | output | 1 | Start pulse to the core |
| conv_chan_o | output | CH_W | Channel of the conversion in flight |
| conv_ref_o | output | 1 | Reference of the conversion in flight |
| busy_o | output | 1 | Conversion in flight |
| power_o | output | 1 | Converter power request |
| result_o | output | 10 | Clamped result |
| res_chan_o | output | CH_W | Channel of the last result |
| discard_o | output | 1 | Last result is suspect |
| res_stb_o | output | 1 | New result strobe |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Completion interrupt request |

## Verification
The assertions assume that the core raises `conv_done_i` only while a conversion is in flight and for one cycle at a time. They also assume that `halted_i` is low out of reset, so its first rising edge is a real sleep entry. The bench's converter stub keeps to this: it waits for a start pulse, holds off a fixed number of cycles and then pulses done once. The one deliberate exception is the abort case, where it still pulses done after the enable has dropped. Sleep entries are made by raising `halted_i` from low only while the sequencer is idle, with mode and enable settings changed only between conversions.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int RES_W = 10;
    localparam logic [RES_W-1:0] RES_MAX = '1;

    typedef enum logic [1:0] {
        SLP_IDLE  = 2'b00,
        SLP_QUIET = 2'b01,
        SLP_DEEP  = 2'b10,
        SLP_STBY  = 2'b11
    } sleep_mode_e;

    typedef struct packed {
        logic busy;
        logic launch;
        logic halt_seen;
        logic pwr;
    } ctrl_state_t;

endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       free_run_i,
    input  logic       start_i,
    input  logic       halted_i,
    input  logic [1:0] sleep_mode_i,
    input  logic       irq_en_i,
    input  logic       done_i,
    output logic       go_o,
    output logic       auto_o,
    output logic       fin_o,
    output logic       busy_o,
    output logic       launch_o,
    output logic       power_o
);

    ctrl_state_t st_d, st_q;
    logic        rise, mode_ok, sleep_go, sw_go, fin, auto_go, go;

    always_comb begin
        rise     = halted_i & ~st_q.halt_seen;
        mode_ok  = (sleep_mode_e'(sleep_mode_i) == SLP_IDLE) ||
                   (sleep_mode_e'(sleep_mode_i) == SLP_QUIET);
        sleep_go = rise & mode_ok & en_i & ~st_q.busy & ~free_run_i & irq_en_i;
        sw_go    = start_i & en_i & ~st_q.busy;
        fin      = done_i & st_q.busy & en_i;
        auto_go  = fin & free_run_i;
        go       = sw_go | sleep_go | auto_go;

        st_d           = st_q;
        st_d.halt_seen = halted_i;
        st_d.launch    = go;
        st_d.pwr       = en_i;
        if (!en_i) begin
            st_d.busy = 1'b0;
        end else if (go) begin
            st_d.busy = 1'b1;
        end else if (fin) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign go_o     = go;
    assign auto_o   = auto_go;
    assign fin_o    = fin;
    assign busy_o   = st_q.busy;
    assign launch_o = st_q.launch;
    assign power_o  = st_q.pwr;

endmodule

// File: rtl/adcseq_shadow.sv
module adcseq_shadow #(
    parameter int CH_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            go_i,
    input  logic            auto_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            ref_i,
    output logic [CH_W-1:0] conv_chan_o,
    output logic            conv_ref_o,
    output logic            suspect_o
);

    typedef struct packed {
        logic [CH_W-1:0] conv_chan;
        logic [CH_W-1:0] pend_chan;
        logic            conv_ref;
        logic            last_ref;
        logic            suspect;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (go_i) begin
            // an automatic restart was already committed when the previous
            // conversion began, so it takes the channel captured back then
            sh_d.conv_chan = auto_i ? sh_q.pend_chan : chan_i;
            sh_d.pend_chan = chan_i;
            sh_d.conv_ref  = ref_i;
            sh_d.suspect   = (ref_i != sh_q.last_ref);
            sh_d.last_ref  = ref_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign conv_chan_o = sh_q.conv_chan;
    assign conv_ref_o  = sh_q.conv_ref;
    assign suspect_o   = sh_q.suspect;

endmodule

// File: rtl/adcseq_result.sv
module adcseq_result
    import adcseq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int RAW_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fin_i,
    input  logic [RAW_W-1:0] raw_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             suspect_i,
    input  logic             clr_i,
    input  logic             ack_i,
    input  logic             irq_en_i,
    output logic [RES_W-1:0] result_o,
    output logic [CH_W-1:0]  res_chan_o,
    output logic             discard_o,
    output logic             stb_o,
    output logic             flag_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [CH_W-1:0]  chan;
        logic             discard;
        logic             stb;
        logic             flag;
    } res_state_t;

    res_state_t rs_d, rs_q;
    logic [RES_W-1:0] clamped;

    generate
        if (RAW_W > RES_W) begin : g_sat
            assign clamped = (|raw_i[RAW_W-1:RES_W]) ? RES_MAX : raw_i[RES_W-1:0];
        end else if (RAW_W == RES_W) begin : g_same
            assign clamped = raw_i;
        end else begin : g_pad
            assign clamped = {{(RES_W-RAW_W){1'b0}}, raw_i};
        end
    endgenerate

    always_comb begin
        rs_d     = rs_q;
        rs_d.stb = fin_i;
        if (clr_i || ack_i) begin
            rs_d.flag = 1'b0;
        end
        if (fin_i) begin
            rs_d.res     = clamped;
            rs_d.chan    = chan_i;
            rs_d.discard = suspect_i;
            rs_d.flag    = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign result_o   = rs_q.res;
    assign res_chan_o = rs_q.chan;
    assign discard_o  = rs_q.discard;
    assign stb_o      = rs_q.stb;
    assign flag_o     = rs_q.flag;
    assign irq_o      = rs_q.flag & irq_en_i;

endmodule

// File: rtl/adc_sleep_seq.sv
module adc_sleep_seq
    import adcseq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int RAW_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             free_run_i,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             ref_sel_i,
    input  logic             irq_en_i,
    input  logic             halted_i,
    input  logic [1:0]       sleep_mode_i,
    input  logic             flag_clr_i,
    input  logic             irq_ack_i,
    input  logic             conv_done_i,
    input  logic [RAW_W-1:0] conv_raw_i,
    output logic             conv_start_o,
    output logic [CH_W-1:0]  conv_chan_o,
    output logic             conv_ref_o,
    output logic             busy_o,
    output logic             power_o,
    output logic [RES_W-1:0] result_o,
    output logic [CH_W-1:0]  res_chan_o,
    output logic             discard_o,
    output logic             res_stb_o,
    output logic             flag_o,
    output logic             irq_o
);

    logic go, auto_go, fin, suspect;

    adcseq_ctrl ctrl_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (en_i),
        .free_run_i   (free_run_i),
        .start_i      (start_i),
        .halted_i     (halted_i),
        .sleep_mode_i (sleep_mode_i),
        .irq_en_i     (irq_en_i),
        .done_i       (conv_done_i),
        .go_o         (go),
        .auto_o       (auto_go),
        .fin_o        (fin),
        .busy_o       (busy_o),
        .launch_o     (conv_start_o),
        .power_o      (power_o)
    );

    adcseq_shadow #(.CH_W(CH_W)) shadow_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .go_i        (go),
        .auto_i      (auto_go),
        .chan_i      (chan_i),
        .ref_i       (ref_sel_i),
        .conv_chan_o (conv_chan_o),
        .conv_ref_o  (conv_ref_o),
        .suspect_o   (suspect)
    );

    adcseq_result #(.CH_W(CH_W), .RAW_W(RAW_W)) result_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fin_i      (fin),
        .raw_i      (conv_raw_i),
        .chan_i     (conv_chan_o),
        .suspect_i  (suspect),
        .clr_i      (flag_clr_i),
        .ack_i      (irq_ack_i),
        .irq_en_i   (irq_en_i),
        .result_o   (result_o),
        .res_chan_o (res_chan_o),
        .discard_o  (discard_o),
        .stb_o      (res_stb_o),
        .flag_o     (flag_o),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
    parameter int CH_W  = 3,
    parameter int RAW_W = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             free_run_i,
    input logic             start_i,
    input logic             irq_en_i,
    input logic             halted_i,
    input logic [1:0]       sleep_mode_i,
    input logic             flag_clr_i,
    input logic             irq_ack_i,
    input logic             conv_done_i,
    input logic [RAW_W-1:0] conv_raw_i,
    input logic             conv_start_o,
    input logic [CH_W-1:0]  conv_chan_o,
    input logic             busy_o,
    input logic             power_o,
    input logic [9:0]       result_o,
    input logic             res_stb_o,
    input logic             flag_o
);

    assert_start_in_flight_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conv_start_o |-> busy_o);

    assert_clamp_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_done_i && busy_o && en_i && int'(conv_raw_i) >= 1023)
        |=> (res_stb_o && result_o == 10'h3FF));

    assert_free_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conv_done_i && busy_o && en_i && free_run_i) |=> (conv_start_o && busy_o));

    assert_chan_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && !conv_start_o) |-> $stable(conv_chan_o));

    assert_sleep_needs_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(halted_i) && !irq_en_i && !start_i && !busy_o) |=> !conv_start_o);

    assert_deep_sleep_no_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(halted_i) && sleep_mode_i[1] && !start_i && !busy_o) |=> !conv_start_o);

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_stb_o |-> flag_o);

    assert_flag_clear_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag_o) |-> $past(flag_clr_i || irq_ack_i));

    assert_disable_abort_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!busy_o && !power_o));

endmodule

bind adc_sleep_seq adcseq_checker #(.CH_W(CH_W), .RAW_W(RAW_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .free_run_i   (free_run_i),
    .start_i      (start_i),
    .irq_en_i     (irq_en_i),
    .halted_i     (halted_i),
    .sleep_mode_i (sleep_mode_i),
    .flag_clr_i   (flag_clr_i),
    .irq_ack_i    (irq_ack_i),
    .conv_done_i  (conv_done_i),
    .conv_raw_i   (conv_raw_i),
    .conv_start_o (conv_start_o),
    .conv_chan_o  (conv_chan_o),
    .busy_o       (busy_o),
    .power_o      (power_o),
    .result_o     (result_o),
    .res_stb_o    (res_stb_o),
    .flag_o       (flag_o)
);

// File: tb/adc_sleep_seq_tb_top.sv
module adc_sleep_seq_tb_top;

    localparam int CH_W  = 3;
    localparam int RAW_W = 12;
    localparam int LAT   = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b1, free_run = 1'b0, start = 1'b0, ref_sel = 1'b0;
    logic [CH_W-1:0]  chan = '0;
    logic             irq_en = 1'b0, halted = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic             main_clr = 1'b0, stub_clr = 1'b0, ack = 1'b0;
    logic             done = 1'b0;
    logic [RAW_W-1:0] raw = '0;
    logic             conv_start, conv_ref, busy, power, discard, res_stb, flag, irq;
    logic [CH_W-1:0]  conv_chan, res_chan;
    logic [9:0]       result;

    always #5 clk = ~clk;

    adc_sleep_seq #(.CH_W(CH_W), .RAW_W(RAW_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .free_run_i(free_run),
        .start_i(start), .chan_i(chan), .ref_sel_i(ref_sel), .irq_en_i(irq_en),
        .halted_i(halted), .sleep_mode_i(mode), .flag_clr_i(main_clr | stub_clr),
        .irq_ack_i(ack), .conv_done_i(done), .conv_raw_i(raw),
        .conv_start_o(conv_start), .conv_chan_o(conv_chan), .conv_ref_o(conv_ref),
        .busy_o(busy), .power_o(power), .result_o(result), .res_chan_o(res_chan),
        .discard_o(discard), .res_stb_o(res_stb), .flag_o(flag), .irq_o(irq)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int raw_tab(input int k);
        case (k)
            0:       return 100;
            1:       return 1023;
            2:       return 1024;
            3:       return 4095;
            default: return (k * 151 + 37) % 4096;
        endcase
    endfunction

    typedef struct {
        int    res;
        int    ch;
        int    disc;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   exp_idx = 0;
    int   pop_cnt = 0;
    int   start_cnt = 0;
    bit   clr_at_done = 1'b0;
    bit   stub_busy = 1'b0;

    // driver side of the scoreboard: predicted result for the next conversion
    task automatic push_exp(input int ch, input int disc, input string req);
        exp_t e;
        int   v;
        v = raw_tab(exp_idx);
        exp_idx++;
        e.res  = (v >= 1023) ? 1023 : v;
        e.ch   = ch;
        e.disc = disc;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // converter stub
    initial begin
        int k;
        k = 0;
        forever begin
            if (conv_start === 1'b1) begin
                stub_busy = 1'b1;
                repeat (LAT) @(negedge clk);
                raw      = RAW_W'(raw_tab(k));
                k++;
                done     = 1'b1;
                stub_clr = clr_at_done;
                @(negedge clk);
                done     = 1'b0;
                stub_clr = 1'b0;
                stub_busy = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && conv_start === 1'b1) start_cnt++;
        if (rst_n && res_stb === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12", "unexpected result", int'(result), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(result) == e.res, e.req, "result", int'(result), e.res);
                chk(int'(res_chan) == e.ch, (e.req == "R3") ? "R3" : "R4",
                    "result channel", int'(res_chan), e.ch);
                chk(int'(discard) == e.disc, "R5", "discard", int'(discard), e.disc);
            end
            pop_cnt++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        cyc(2);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_clr();
        main_clr = 1'b1;
        @(negedge clk);
        main_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int s0;
        cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(flag == 1'b0, "R10", "reset flag", int'(flag), 0);
        chk(irq == 1'b0, "R11", "reset irq", int'(irq), 0);
        chk(conv_start == 1'b0, "R1", "reset start", int'(conv_start), 0);
        chk(result == 10'd0, "R2", "reset result", int'(result), 0);
        chk(power == 1'b1, "R8", "power follows enable", int'(power), 1);

        // R1 / R4: software start, channel written mid-conversion
        chan = 3'd3;
        push_exp(3, 0, "R2");
        pulse_start();
        chk(conv_start == 1'b1, "R1", "start pulse", int'(conv_start), 1);
        chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
        chan = 3'd6;
        cyc(2);
        chk(int'(conv_chan) == 3, "R4", "shadow channel", int'(conv_chan), 3);
        wait_idle();
        chk(busy == 1'b0, "R1", "busy after done", int'(busy), 0);
        chk(flag == 1'b1, "R10", "flag set", int'(flag), 1);
        chk(irq == 1'b0, "R11", "irq masked", int'(irq), 0);

        // R10: explicit clear, then set-wins on simultaneous clear
        pulse_clr();
        chk(flag == 1'b0, "R10", "flag cleared", int'(flag), 0);
        chan = 3'd2;
        clr_at_done = 1'b1;
        push_exp(2, 0, "R2");
        pulse_start();
        wait_idle();
        clr_at_done = 1'b0;
        chk(flag == 1'b1, "R10", "set wins over clear", int'(flag), 1);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(flag == 1'b0, "R10", "ack clears flag", int'(flag), 0);

        // R5 / R2: reference switches, clamped codes
        ref_sel = 1'b1;
        chan = 3'd4;
        push_exp(4, 1, "R2");
        pulse_start();
        wait_idle();
        push_exp(4, 0, "R2");
        pulse_start();
        wait_idle();
        ref_sel = 1'b0;
        push_exp(4, 1, "R5");
        pulse_start();
        wait_idle();

        // R3 / R4: free-running with a channel write during the first conversion
        free_run = 1'b1;
        chan = 3'd1;
        s0 = start_cnt;
        push_exp(1, 0, "R3");
        push_exp(1, 0, "R3");
        push_exp(5, 0, "R3");
        push_exp(5, 0, "R3");
        pulse_start();
        cyc(2);
        chan = 3'd5;
        wait (pop_cnt == 8);
        @(negedge clk);
        free_run = 1'b0;
        wait_idle();
        chk(start_cnt - s0 == 4, "R3", "free-run start count", start_cnt - s0, 4);
        chk(busy == 1'b0, "R3", "run ends", int'(busy), 0);

        // R6 / R7 / R11: sleep-triggered conversion in noise-reduction mode
        pulse_clr();
        irq_en = 1'b1;
        mode = 2'b01;
        chan = 3'd0;
        s0 = start_cnt;
        push_exp(0, 0, "R6");
        halted = 1'b1;
        @(negedge clk);
        chk(conv_start == 1'b1, "R6", "sleep start", int'(conv_start), 1);
        while (!irq) @(negedge clk);
        chk(irq == 1'b1, "R11", "irq wakes", int'(irq), 1);
        cyc(10);
        chk(start_cnt - s0 == 1, "R7", "single start per entry", start_cnt - s0, 1);
        halted = 1'b0;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(irq == 1'b0, "R11", "irq after ack", int'(irq), 0);

        // R9: idle-mode entry, early wake by another source
        mode = 2'b00;
        s0 = start_cnt;
        push_exp(0, 0, "R9");
        halted = 1'b1;
        @(negedge clk);
        chk(conv_start == 1'b1, "R6", "idle-mode start", int'(conv_start), 1);
        halted = 1'b0;
        wait_idle();
        chk(flag == 1'b1, "R9", "flag after early wake", int'(flag), 1);
        chk(irq == 1'b1, "R9", "irq after early wake", int'(irq), 1);
        pulse_clr();

        // R8 / R6: sleep entries that must not start anything
        s0 = start_cnt;
        mode = 2'b10;
        halted = 1'b1;
        cyc(5);
        chk(power == 1'b1, "R8", "power kept in deep sleep", int'(power), 1);
        halted = 1'b0;
        cyc(2);
        mode = 2'b11;
        halted = 1'b1;
        cyc(5);
        halted = 1'b0;
        cyc(2);
        chk(start_cnt == s0, "R8", "deep modes no start", start_cnt - s0, 0);
        mode = 2'b01;
        irq_en = 1'b0;
        halted = 1'b1;
        cyc(5);
        halted = 1'b0;
        cyc(2);
        irq_en = 1'b1;
        free_run = 1'b1;
        halted = 1'b1;
        cyc(5);
        halted = 1'b0;
        free_run = 1'b0;
        cyc(2);
        chk(start_cnt == s0, "R6", "blocked sleep entries", start_cnt - s0, 0);

        // R12: abort by disabling
        irq_en = 1'b0;
        chan = 3'd1;
        pulse_start();
        exp_idx++;
        cyc(1);
        en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R12", "abort clears busy", int'(busy), 0);
        chk(power == 1'b0, "R12", "power off", int'(power), 0);
        wait (stub_busy == 1'b0);
        cyc(3);
        chk(flag == 1'b0, "R12", "late done ignored", int'(flag), 0);
        en = 1'b1;
        cyc(2);
        chk(power == 1'b1, "R8", "power back on", int'(power), 1);
        chk(exp_q.size() == 0, "R2", "all results seen", exp_q.size(), 0);
        finish_run();
    end

endmodule